// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Controller

This block sits between a UART's serializers and the bus side. It holds outgoing and incoming characters in two FIFOs of `DEPTH` entries each (16 by default). Each direction has a programmable trigger threshold, which drives a level interrupt. A control write can empty either FIFO in one cycle through strobe bits that are never stored. When the FIFO enable bit is clear, each direction falls back to a holding register of one entry.

A status word reports both occupancy counts and both full flags. An optional hardware flow control mode does two things. It raises the active-low request-to-send pin when the receive FIFO is within one entry of full. It also stops the transmit serializer from taking a new character while clear-to-send is inactive. When this mode is off, request-to-send follows a bit set by software. A modem status byte shows the sampled clear-to-send level and a delta flag. The delta flag latches any change of clear-to-send and clears when the modem status is read.

Top module: `uart_fifo_ctl`

## Requirements
- R1: A write to `ctl_wdata` stores the enable in bit 0, the receive trigger code in bits 5:4 and the transmit trigger code in bits 7:6. Trigger codes 0, 1, 2 and 3 select thresholds of 4, 8, 12 and 16 entries (DEPTH/4 times code+1).
- R2: With the FIFO enabled, each FIFO gives its data back in push order and holds at most DEPTH entries. A push while the FIFO is full is ignored. A pop while it is empty is ignored.
- R3: `fifo_stat` holds the receive count modulo DEPTH in bits 3:0 and the transmit count modulo DEPTH in bits 7:4. Receive-full is at bit 8 and transmit-full at bit 9.
- R4: With the enable bit at 0, each FIFO holds one entry. It reports full once that entry is present, and further pushes are ignored.
- R5: `rx_irq` is high while the receive count is at or above the receive threshold (in single-entry mode: while it holds data).
- R6: `tx_irq` is high while the transmit count is at or below the transmit threshold (in single-entry mode: while it is empty).
- R7: A control write with bit 1 (receive) or bit 2 (transmit) set empties that FIFO at the same clock edge and leaves the other FIFO untouched. These bits are not stored, so the next push is accepted normally.
- R8: With auto flow control on (modem control bit 4), `rts_n` is 1 while the receive count is DEPTH-1 or more, and 0 otherwise.
- R9: With auto flow control off, `rts_n` is the inverse of modem control bit 0, so a 1 in that bit drives the pin low.
- R10: With auto flow control on and clear-to-send inactive, `ser_tx_valid` is 0 and `ser_tx_pop` is ignored. With auto flow control off, clear-to-send has no effect.
- R11: `msr` bit 0 shows clear-to-send active (`cts_n` low), sampled one clock after the pin. `msr` bit 2 is set one clock after any change of that sample and is cleared by `msr_rd`; a new change wins over the clear. All other bits of `msr` are 0.
- R12: After reset both FIFOs are empty and `fifo_stat` is 0. The enable bit is 0, `rx_irq` is 0, `tx_irq` is 1, `rts_n` is 1 and `msr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | FIFO control write strobe |
| ctl_wdata | input | 8 | FIFO control write data |
| mcon_wr | input | 1 | Modem control write strobe |
| mcon_wdata | input | 8 | Modem control write data |
| msr_rd | input | 1 | Modem status read strobe (clears delta flag) |
| msr | output | 8 | Modem status: bit 0 CTS active, bit 2 delta CTS |
| bus_tx_push | input | 1 | Bus pushes a character into the transmit FIFO |
| bus_tx_data | input | W | Character to transmit |
| bus_rx_pop | input | 1 | Bus pops the receive FIFO |
| bus_rx_data | output | W | Head of the receive FIFO |
| ser_tx_valid | output | 1 | Transmit character available and permitted |
| ser_tx_pop | input | 1 | Transmit serializer takes the head character |
| ser_tx_data | output | W | Head of the transmit FIFO |
| ser_rx_push | input | 1 | Receive serializer delivers a character |
| ser_rx_data | input | W | Received character |
| fifo_stat | output | 2*log2(DEPTH)+2 | Occupancy counts and full flags |
| rx_irq | output | 1 | Receive trigger interrupt (level) |
| tx_irq | output | 1 | Transmit trigger interrupt (level) |
| rts_n | output | 1 | Request-to-send pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |

## Verification
The assertions check on every cycle that no FIFO count exceeds its depth and that a push into a full FIFO leaves the count unchanged. They also check that a clear strobe empties its FIFO, that the delta-CTS flag sets after a change and clears on a read, and that a held-off transmit pop changes nothing. Only the bench scenarios can show behaviour that spans many cycles or depends on data. That covers the ordering of data through the FIFOs, the threshold for each trigger code, and the exact request-to-send turn-off point at fifteen entries. It also covers the single-entry fallback and the fact that a reset of one FIFO leaves the other untouched.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // FIFO control byte; field positions are decoded by software.
    typedef struct packed {
        logic [1:0] tx_trig;
        logic [1:0] rx_trig;
        logic       rsv;
        logic       tx_clr;
        logic       rx_clr;
        logic       en;
    } fifo_ctl_t;

    // Modem control byte.
    typedef struct packed {
        logic [2:0] rsv_hi;
        logic       afc;
        logic [2:0] rsv_lo;
        logic       rts_sw;
    } modem_ctl_t;

    // Threshold selected by a two-bit trigger code: quarters of the depth.
    function automatic int trig_level(input logic [1:0] code, input int depth);
        return ((int'(code) + 1) * depth) / 4;
    endfunction

endpackage

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = AW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            single,
    input  logic            push,
    input  logic [W-1:0]    din,
    input  logic            pop,
    output logic [W-1:0]    dout,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = single ? !empty : (count == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH));

    // R2
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> count == $past(count));

    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
    parameter int DEPTH = 16,
    localparam int CNTW = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cts_n,
    input  logic            msr_rd,
    input  logic            afc,
    input  logic            rts_sw,
    input  logic [CNTW-1:0] rx_count,
    output logic            cts_act,
    output logic [7:0]      msr,
    output logic            rts_n
);
    logic cts_act_d;
    logic dcts;
    logic changed;

    assign changed = (cts_act != cts_act_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_act   <= 1'b0;
            cts_act_d <= 1'b0;
            dcts      <= 1'b0;
        end else begin
            cts_act   <= !cts_n;
            cts_act_d <= cts_act;
            if (changed)     dcts <= 1'b1;
            else if (msr_rd) dcts <= 1'b0;
        end
    end

    assign msr   = {5'b0, dcts, 1'b0, cts_act};
    assign rts_n = afc ? (int'(rx_count) >= DEPTH - 1) : !rts_sw;

    // R11
    dcts_set_chk: assert property (@(posedge clk) disable iff (rst)
        changed |=> msr[2]);

    // R11
    dcts_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_rd && !changed) |=> !msr[2]);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = AW + 1,
    localparam int SW   = 2 * AW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    input  logic          mcon_wr,
    input  logic [7:0]    mcon_wdata,
    input  logic          msr_rd,
    output logic [7:0]    msr,
    input  logic          bus_tx_push,
    input  logic [W-1:0]  bus_tx_data,
    input  logic          bus_rx_pop,
    output logic [W-1:0]  bus_rx_data,
    output logic          ser_tx_valid,
    input  logic          ser_tx_pop,
    output logic [W-1:0]  ser_tx_data,
    input  logic          ser_rx_push,
    input  logic [W-1:0]  ser_rx_data,
    output logic [SW-1:0] fifo_stat,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          rts_n,
    input  logic          cts_n
);
    fifo_ctl_t  ctl_q, ctl_in;
    modem_ctl_t mcon_q;
    logic       rx_clr, tx_clr, single, permit, cts_act;
    logic [CNTW-1:0] rx_cnt, tx_cnt;
    logic rx_full, rx_empty, tx_full, tx_empty;

    assign ctl_in = fifo_ctl_t'(ctl_wdata);
    assign rx_clr = ctl_wr && ctl_in.rx_clr;
    assign tx_clr = ctl_wr && ctl_in.tx_clr;
    assign single = !ctl_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            mcon_q <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q        <= ctl_in;
                ctl_q.rx_clr <= 1'b0;
                ctl_q.tx_clr <= 1'b0;
                ctl_q.rsv    <= 1'b0;
            end
            if (mcon_wr) mcon_q <= modem_ctl_t'(mcon_wdata);
        end
    end

    uart_fifo_buf #(.W(W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst(rst), .clr(rx_clr), .single(single),
        .push(ser_rx_push), .din(ser_rx_data), .pop(bus_rx_pop),
        .dout(bus_rx_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign permit = !mcon_q.afc || cts_act;

    uart_fifo_buf #(.W(W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst(rst), .clr(tx_clr), .single(single),
        .push(bus_tx_push), .din(bus_tx_data), .pop(ser_tx_pop && permit),
        .dout(ser_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    uart_flow_ctl #(.DEPTH(DEPTH)) u_flow (
        .clk(clk), .rst(rst), .cts_n(cts_n), .msr_rd(msr_rd),
        .afc(mcon_q.afc), .rts_sw(mcon_q.rts_sw), .rx_count(rx_cnt),
        .cts_act(cts_act), .msr(msr), .rts_n(rts_n)
    );

    assign ser_tx_valid = !tx_empty && permit;
    assign fifo_stat    = {tx_full, rx_full, tx_cnt[AW-1:0], rx_cnt[AW-1:0]};

    always_comb begin
        if (single) begin
            rx_irq = !rx_empty;
            tx_irq = tx_empty;
        end else begin
            rx_irq = int'(rx_cnt) >= trig_level(ctl_q.rx_trig, DEPTH);
            tx_irq = int'(tx_cnt) <= trig_level(ctl_q.tx_trig, DEPTH);
        end
    end

    // R10
    cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mcon_q.afc && !cts_act && ser_tx_pop && !bus_tx_push && !tx_clr)
        |=> tx_cnt == $past(tx_cnt));

endmodule

// File: tb/tb_uart_fifo_ctl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctl;
    localparam int W = 8;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 0, mcon_wr = 0, msr_rd = 0;
    logic [7:0] ctl_wdata = 0, mcon_wdata = 0, msr;
    logic bus_tx_push = 0, bus_rx_pop = 0, ser_tx_pop = 0, ser_rx_push = 0;
    logic [W-1:0] bus_tx_data = 0, ser_rx_data = 0, bus_rx_data, ser_tx_data;
    logic ser_tx_valid, rx_irq, tx_irq, rts_n;
    logic cts_n = 1'b1;
    logic [9:0] fifo_stat;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    uart_fifo_ctl #(.W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .mcon_wr(mcon_wr), .mcon_wdata(mcon_wdata), .msr_rd(msr_rd), .msr(msr),
        .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
        .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
        .ser_tx_valid(ser_tx_valid), .ser_tx_pop(ser_tx_pop),
        .ser_tx_data(ser_tx_data), .ser_rx_push(ser_rx_push),
        .ser_rx_data(ser_rx_data), .fifo_stat(fifo_stat), .rx_irq(rx_irq),
        .tx_irq(tx_irq), .rts_n(rts_n), .cts_n(cts_n)
    );

    typedef struct packed {
        logic [1:0] trig;
        logic [4:0] n;
        logic       irq;
        logic       rts;
    } vec_t;

    // Receive fill level against trigger code, with auto flow control on.
    localparam vec_t VEC [9] = '{
        '{2'd0, 5'd3,  1'b0, 1'b0},
        '{2'd0, 5'd4,  1'b1, 1'b0},
        '{2'd1, 5'd7,  1'b0, 1'b0},
        '{2'd1, 5'd8,  1'b1, 1'b0},
        '{2'd2, 5'd11, 1'b0, 1'b0},
        '{2'd2, 5'd12, 1'b1, 1'b0},
        '{2'd3, 5'd14, 1'b0, 1'b0},
        '{2'd3, 5'd15, 1'b0, 1'b1},
        '{2'd3, 5'd16, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0;
    endtask

    task automatic wr_mcon(input logic [7:0] v);
        mcon_wr = 1; mcon_wdata = v; tick(); mcon_wr = 0;
    endtask

    task automatic rx_in(input logic [7:0] d);
        ser_rx_push = 1; ser_rx_data = d; tick(); ser_rx_push = 0;
    endtask

    task automatic tx_in(input logic [7:0] d);
        bus_tx_push = 1; bus_tx_data = d; tick(); bus_tx_push = 0;
    endtask

    task automatic tx_take(input string tag, input logic [7:0] exp);
        chk(tag, {24'b0, ser_tx_data}, {24'b0, exp});
        ser_tx_pop = 1; tick(); ser_tx_pop = 0;
    endtask

    task automatic rx_take(input string tag, input logic [7:0] exp);
        chk(tag, {24'b0, bus_rx_data}, {24'b0, exp});
        bus_rx_pop = 1; tick(); bus_rx_pop = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R12 reset state
        chk("R12 stat", {22'b0, fifo_stat}, 0);
        chk("R12 rx_irq", {31'b0, rx_irq}, 0);
        chk("R12 tx_irq", {31'b0, tx_irq}, 1);
        chk("R12 rts_n", {31'b0, rts_n}, 1);
        chk("R12 msr", {24'b0, msr}, 0);
        chk("R12 tx_valid", {31'b0, ser_tx_valid}, 0);

        // R1 R5 R8 R3: trigger table walk, auto flow control on
        wr_mcon(8'h10);
        for (int v = 0; v < 9; v++) begin
            wr_ctl({2'b00, VEC[v].trig, 4'b0111});
            for (int k = 0; k < int'(VEC[v].n); k++) rx_in(8'(k));
            chk("R5 rx_irq", {31'b0, rx_irq}, {31'b0, VEC[v].irq});
            chk("R8 rts_n", {31'b0, rts_n}, {31'b0, VEC[v].rts});
            chk("R3 stat", {22'b0, fifo_stat},
                (VEC[v].n == 5'd16) ? 32'h100 : {28'b0, VEC[v].n[3:0]});
        end

        // R11 CTS sampling and delta flag
        cts_n = 0;
        tick();
        chk("R11 cts", {31'b0, msr[0]}, 1);
        tick();
        chk("R11 dcts set", {24'b0, msr}, 32'h05);
        msr_rd = 1; tick(); msr_rd = 0;
        chk("R11 dcts clear", {24'b0, msr}, 32'h01);

        // R6 R2: transmit trigger 8, ordering
        wr_ctl(8'h47);
        for (int k = 0; k < 9; k++) tx_in(8'h10 + 8'(k));
        chk("R3 tx count", {28'b0, fifo_stat[7:4]}, 9);
        chk("R6 tx_irq above", {31'b0, tx_irq}, 0);
        tx_take("R2 order", 8'h10);
        chk("R6 tx_irq at", {31'b0, tx_irq}, 1);
        for (int k = 1; k < 9; k++) tx_take("R2 order", 8'h10 + 8'(k));
        chk("R2 tx empty", {22'b0, fifo_stat}, 0);
        ser_tx_pop = 1; tick(); ser_tx_pop = 0;
        chk("R2 pop empty ignored", {22'b0, fifo_stat}, 0);

        // R10 hold-off while CTS inactive
        tx_in(8'hA1); tx_in(8'hA2);
        cts_n = 1;
        tick();
        chk("R10 valid held", {31'b0, ser_tx_valid}, 0);
        ser_tx_pop = 1; tick(); ser_tx_pop = 0;
        chk("R10 pop ignored", {28'b0, fifo_stat[7:4]}, 2);
        chk("R11 dcts on fall", {31'b0, msr[2]}, 1);
        cts_n = 0;
        tick();
        chk("R10 valid resumes", {31'b0, ser_tx_valid}, 1);
        tx_take("R10 data", 8'hA1);
        tx_take("R10 data", 8'hA2);

        // R2 overflow: 17 pushes keep the first 16
        wr_ctl(8'h07);
        for (int k = 0; k < 17; k++) rx_in(8'h20 + 8'(k));
        chk("R2 rx full", {22'b0, fifo_stat}, 32'h100);
        for (int k = 0; k < 16; k++) rx_take("R2 rx order", 8'h20 + 8'(k));
        chk("R2 rx drained", {22'b0, fifo_stat}, 0);

        // R7 reset bits affect only their own FIFO and are not stored
        rx_in(8'h01); rx_in(8'h02); rx_in(8'h03);
        tx_in(8'hB1); tx_in(8'hB2);
        wr_ctl(8'h03);
        chk("R7 rx cleared", {22'b0, fifo_stat}, 32'h020);
        rx_in(8'h44);
        chk("R7 push after clear", {22'b0, fifo_stat}, 32'h021);
        chk("R7 data after clear", {24'b0, bus_rx_data}, 32'h44);
        wr_ctl(8'h05);
        chk("R7 tx cleared", {22'b0, fifo_stat}, 32'h001);

        // R4 single-entry mode
        wr_ctl(8'h06);
        rx_in(8'h55); rx_in(8'h66);
        tx_in(8'h77); tx_in(8'h88);
        chk("R4 stat", {22'b0, fifo_stat}, 32'h311);
        chk("R4 rx data", {24'b0, bus_rx_data}, 32'h55);
        chk("R4 tx data", {24'b0, ser_tx_data}, 32'h77);
        chk("R4 rx_irq", {31'b0, rx_irq}, 1);
        chk("R4 tx_irq", {31'b0, tx_irq}, 0);

        // R9 software RTS, and CTS ignored with flow control off
        wr_mcon(8'h01);
        chk("R9 rts low", {31'b0, rts_n}, 0);
        cts_n = 1;
        tick(); tick();
        chk("R10 cts ignored", {31'b0, ser_tx_valid}, 1);
        wr_mcon(8'h00);
        chk("R9 rts high", {31'b0, rts_n}, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule